// File: doc/BRIEF.md
# Shared Pad Power Sequencer

This block drives three power-control bits for a bank of I/O pads: a core power-down bit, an early isolation clamp and a final isolation clamp. Several PHY clients share the bank. Each client asks for power with a one-cycle request pulse and gives it up with a one-cycle release pulse. An internal user count records how many clients hold the pads. Only the first request, which takes the count from zero to one, powers the pads up. Only the last release, which takes the count back to zero, powers them down.

Power-up drops the bits one at a time, starting with the final clamp, then the early clamp, then core power-down. Each step is separated by a fixed dwell of `GAP_CYCLES` clock cycles. Power-down raises them again in the mirrored order with the same dwell. At 125 MHz the default of 12500 cycles gives a 100 µs dwell. Any value between 100 µs and 200 µs of clock time is acceptable to the pads.

While a sequence runs the block reports busy and ignores new pulses. Each request or release is answered with either an acknowledge pulse or, for a release with no holders, a warning pulse.

Top module: `pad_pwr_seq`

## Requirements
- R1: After reset `pad_ctl_o` is 3'b111, `busy_o`, `ack_o` and `warn_o` are low, and the user count is zero. The first request after reset therefore runs the power-up sequence.
- R2: `pad_ctl_o` bit 2 is core power-down, bit 1 the early clamp and bit 0 the final clamp; a 1 asserts the bit. A request accepted with a zero count clears bit 0 on the accepting edge, clears bit 1 `GAP_CYCLES` cycles later and clears bit 2 `GAP_CYCLES` cycles after that.
- R3: Within a sequence, successive bit changes are exactly `GAP_CYCLES` cycles apart, and each change alters exactly one bit.
- R4: A release that takes the count from one to zero sets bit 2 on the accepting edge, then bit 1, then bit 0, with the same spacing as R2.
- R5: A request accepted with a nonzero count increments the count, pulses `ack_o` on the cycle after the accepting edge, and leaves `pad_ctl_o` unchanged.
- R6: `busy_o` is high from the accepting edge of a sequence until the edge of its last bit change. On that edge `busy_o` falls and `ack_o` pulses for one cycle.
- R7: A release accepted with a count above one decrements the count, pulses `ack_o` on the following cycle and leaves `pad_ctl_o` unchanged.
- R8: A release accepted with a zero count pulses `warn_o` for one cycle instead of `ack_o`, and changes neither the count nor `pad_ctl_o`.
- R9: Requests and releases presented while `busy_o` is high are ignored. They affect neither the count nor the sequence.
- R10: When a request and a release arrive in the same idle cycle, the request is taken and the release is dropped.
- R11: The user count saturates at 2^`USER_W`-1. A request at that value is acknowledged and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle request pulse from a client |
| rel_i | input | 1 | One-cycle release pulse from a client |
| busy_o | output | 1 | A power sequence is in progress |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request or release |
| warn_o | output | 1 | One-cycle warning: release with no holders |
| pad_ctl_o | output | 3 | {core power-down, early clamp, final clamp}, 1 = asserted |

## Verification
The assertions assume that clients present pulses only at clock edges. They also assume clients tolerate having pulses dropped while busy, so they do not constrain what arrives during a sequence. The timing assertion assumes `GAP_CYCLES` is at least one. It measures dwell only between changes that start from a mixed pad state, because a new sequence may begin one cycle after the previous one acknowledges. The stimulus drives pulses one cycle wide from the falling edge. It deliberately injects pulses during a running sequence and simultaneous request and release, so the hold-off and priority rules are exercised rather than assumed.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef struct packed {
        logic core_pd;
        logic clamp_early;
        logic clamp;
    } pad_ctl_t;

    localparam pad_ctl_t PADS_ASSERTED = 3'b111;
    localparam pad_ctl_t PADS_RELEASED = 3'b000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_GAP1,
        ST_UP_GAP2,
        ST_DN_GAP1,
        ST_DN_GAP2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ACQUIRE,
        OP_RELEASE
    } op_e;

    // Pulses are dropped while busy; a request wins over a same-cycle release.
    function automatic op_e decode_op(input logic acq, input logic rel, input logic busy);
        if (busy) return OP_NONE;
        if (acq)  return OP_ACQUIRE;
        if (rel)  return OP_RELEASE;
        return OP_NONE;
    endfunction

    function automatic int unsigned timer_width(input int unsigned gap);
        return (gap > 1) ? $clog2(gap) : 1;
    endfunction

endpackage

// File: rtl/pps_user_count.sv
module pps_user_count #(
    parameter int unsigned USER_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic is_zero,
    output logic is_one
);
    localparam logic [USER_W-1:0] CNT_MAX = '1;
    localparam logic [USER_W-1:0] CNT_ONE = USER_W'(1);

    logic [USER_W-1:0] users_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            users_q <= '0;
        end else if (inc && users_q != CNT_MAX) begin
            users_q <= users_q + CNT_ONE;
        end else if (dec && users_q != '0) begin
            users_q <= users_q - CNT_ONE;
        end
    end

    assign is_zero = (users_q == '0);
    assign is_one  = (users_q == CNT_ONE);

endmodule

// File: rtl/pps_gap_timer.sv
module pps_gap_timer #(
    parameter int unsigned GAP_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int unsigned TW = pps_pkg::timer_width(GAP_CYCLES);
    localparam logic [TW-1:0] LOAD_VAL = TW'(GAP_CYCLES - 1);

    logic [TW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= LOAD_VAL;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - TW'(1);
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/pps_step_fsm.sv
module pps_step_fsm
    import pps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     acq,
    input  logic     rel,
    input  logic     cnt_zero,
    input  logic     cnt_one,
    input  logic     gap_done,
    output logic     cnt_inc,
    output logic     cnt_dec,
    output logic     gap_load,
    output pad_ctl_t pads,
    output logic     busy,
    output logic     ack,
    output logic     warn
);
    seq_state_e state_q, state_d;
    pad_ctl_t   pads_q, pads_d;
    logic       ack_q, ack_d;
    logic       warn_q, warn_d;
    op_e        op;

    assign busy = (state_q != ST_IDLE);
    assign op   = decode_op(acq, rel, busy);

    always_comb begin
        state_d  = state_q;
        pads_d   = pads_q;
        ack_d    = 1'b0;
        warn_d   = 1'b0;
        cnt_inc  = 1'b0;
        cnt_dec  = 1'b0;
        gap_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op == OP_ACQUIRE) begin
                    cnt_inc = 1'b1;
                    if (cnt_zero) begin
                        pads_d.clamp = 1'b0;
                        gap_load     = 1'b1;
                        state_d      = ST_UP_GAP1;
                    end else begin
                        ack_d = 1'b1;
                    end
                end else if (op == OP_RELEASE) begin
                    if (cnt_zero) begin
                        warn_d = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                        if (cnt_one) begin
                            pads_d.core_pd = 1'b1;
                            gap_load       = 1'b1;
                            state_d        = ST_DN_GAP1;
                        end else begin
                            ack_d = 1'b1;
                        end
                    end
                end
            end
            ST_UP_GAP1: begin
                if (gap_done) begin
                    pads_d.clamp_early = 1'b0;
                    gap_load           = 1'b1;
                    state_d            = ST_UP_GAP2;
                end
            end
            ST_UP_GAP2: begin
                if (gap_done) begin
                    pads_d.core_pd = 1'b0;
                    ack_d          = 1'b1;
                    state_d        = ST_IDLE;
                end
            end
            ST_DN_GAP1: begin
                if (gap_done) begin
                    pads_d.clamp_early = 1'b1;
                    gap_load           = 1'b1;
                    state_d            = ST_DN_GAP2;
                end
            end
            ST_DN_GAP2: begin
                if (gap_done) begin
                    pads_d.clamp = 1'b1;
                    ack_d        = 1'b1;
                    state_d      = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pads_q  <= PADS_ASSERTED;
            ack_q   <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pads_q  <= pads_d;
            ack_q   <= ack_d;
            warn_q  <= warn_d;
        end
    end

    assign pads = pads_q;
    assign ack  = ack_q;
    assign warn = warn_q;

endmodule

// File: rtl/pad_pwr_seq.sv
module pad_pwr_seq #(
    parameter int unsigned GAP_CYCLES = 12500,
    parameter int unsigned USER_W     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       rel_i,
    output logic       busy_o,
    output logic       ack_o,
    output logic       warn_o,
    output logic [2:0] pad_ctl_o
);
    import pps_pkg::*;

    logic     cnt_inc, cnt_dec, cnt_zero, cnt_one;
    logic     gap_load, gap_done;
    pad_ctl_t pads;

    pps_user_count #(.USER_W(USER_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    pps_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_done)
    );

    pps_step_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .acq      (req_i),
        .rel      (rel_i),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .gap_done (gap_done),
        .cnt_inc  (cnt_inc),
        .cnt_dec  (cnt_dec),
        .gap_load (gap_load),
        .pads     (pads),
        .busy     (busy_o),
        .ack      (ack_o),
        .warn     (warn_o)
    );

    assign pad_ctl_o = pads;

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int unsigned GAP_CYCLES = 12500
) (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic       rel_i,
    input logic [2:0] pad_ctl,
    input logic       busy,
    input logic       ack,
    input logic       warn
);
    localparam int unsigned CW = $clog2(GAP_CYCLES + 1) + 1;
    localparam logic [CW-1:0] SAT = CW'(GAP_CYCLES);
    localparam logic [CW-1:0] MIN_SINCE = CW'(GAP_CYCLES - 1);

    logic [2:0]    prev_pads;
    logic [CW-1:0] since_chg;
    logic          prev_mixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pads <= 3'b111;
            since_chg <= SAT;
        end else begin
            prev_pads <= pad_ctl;
            if (pad_ctl != prev_pads)   since_chg <= '0;
            else if (since_chg != SAT)  since_chg <= since_chg + CW'(1);
        end
    end

    assign prev_mixed = (prev_pads != 3'b000) && (prev_pads != 3'b111);

    AST_PAD_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!pad_ctl[0] || pad_ctl[1]) && (!pad_ctl[1] || pad_ctl[2])); // R2 R4
    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pad_ctl != prev_pads) |-> ($countones(pad_ctl ^ prev_pads) == 1)); // R3
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        ((pad_ctl != prev_pads) && prev_mixed) |-> (since_chg >= MIN_SINCE)); // R3
    AST_MIXED_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((pad_ctl != 3'b000) && (pad_ctl != 3'b111)) |-> busy); // R6
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        ack |-> !busy); // R6
    AST_ACK_PROMPTED: assert property (@(posedge clk) disable iff (rst)
        ack |-> ($past(busy) || $past(req_i) || $past(rel_i))); // R5
    AST_ACK_WARN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack && warn)); // R8
    AST_WARN_POWERED_DOWN: assert property (@(posedge clk) disable iff (rst)
        warn |-> (pad_ctl == 3'b111) && $past(rel_i)); // R8

endmodule

bind pad_pwr_seq pps_checker #(.GAP_CYCLES(GAP_CYCLES)) u_pps_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .rel_i   (rel_i),
    .pad_ctl (pad_ctl_o),
    .busy    (busy_o),
    .ack     (ack_o),
    .warn    (warn_o)
);

// File: tb/tb_pad_pwr_seq.sv
`timescale 1ns/1ps
module tb_pad_pwr_seq;
    localparam int unsigned GAP = 6;
    localparam int unsigned UW  = 2;

    localparam logic [1:0] OP_REQ  = 2'd0;
    localparam logic [1:0] OP_REL  = 2'd1;
    localparam logic [1:0] OP_BOTH = 2'd2;
    localparam logic [1:0] EX_ACK  = 2'd0;
    localparam logic [1:0] EX_UP   = 2'd1;
    localparam logic [1:0] EX_DN   = 2'd2;
    localparam logic [1:0] EX_WARN = 2'd3;

    // {operation, expected outcome}; count in comment after each step
    localparam int NVEC = 13;
    localparam logic [3:0] VEC [NVEC] = '{
        {OP_REL,  EX_WARN},  // 0  R8
        {OP_REQ,  EX_UP},    // 1  R2
        {OP_REQ,  EX_ACK},   // 2  R5
        {OP_REQ,  EX_ACK},   // 3  R5
        {OP_REQ,  EX_ACK},   // 3  R11 saturated
        {OP_REL,  EX_ACK},   // 2  R7
        {OP_REL,  EX_ACK},   // 1  R7
        {OP_REL,  EX_DN},    // 0  R4
        {OP_REL,  EX_WARN},  // 0  R8
        {OP_BOTH, EX_UP},    // 1  R10
        {OP_BOTH, EX_ACK},   // 2  R10
        {OP_REL,  EX_ACK},   // 1
        {OP_REL,  EX_DN}     // 0
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_i = 1'b0;
    logic       rel_i = 1'b0;
    logic       busy_o, ack_o, warn_o;
    logic [2:0] pad_ctl_o;

    int nchk  = 0;
    int nfail = 0;
    logic [2:0] cur_pads = 3'b111;

    always #4 clk = ~clk;

    pad_pwr_seq #(.GAP_CYCLES(GAP), .USER_W(UW)) dut (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .rel_i     (rel_i),
        .busy_o    (busy_o),
        .ack_o     (ack_o),
        .warn_o    (warn_o),
        .pad_ctl_o (pad_ctl_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // Called at the negedge just after the accepting edge.
    task automatic run_seq(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c, input string rq);
        chk(rq, pad_ctl_o, a);
        chk("R6 busy", busy_o, 1);
        repeat (GAP - 1) @(negedge clk);
        chk("R3 dwell", pad_ctl_o, a);
        @(negedge clk);
        chk(rq, pad_ctl_o, b);
        chk("R6 no ack", ack_o, 0);
        repeat (GAP - 1) @(negedge clk);
        chk("R3 dwell", pad_ctl_o, b);
        @(negedge clk);
        chk(rq, pad_ctl_o, c);
        chk("R6 ack", ack_o, 1);
        chk("R6 idle", busy_o, 0);
        cur_pads = c;
    endtask

    task automatic apply(input logic [1:0] op, input logic [1:0] ex);
        @(negedge clk);
        req_i = (op == OP_REQ) || (op == OP_BOTH);
        rel_i = (op == OP_REL) || (op == OP_BOTH);
        @(negedge clk);
        req_i = 1'b0;
        rel_i = 1'b0;
        case (ex)
            EX_ACK: begin
                chk("R5/R7 ack", ack_o, 1);
                chk("R5/R7 idle", busy_o, 0);
                chk("R5/R7 pads", pad_ctl_o, cur_pads);
            end
            EX_WARN: begin
                chk("R8 warn", warn_o, 1);
                chk("R8 ack", ack_o, 0);
                chk("R8 pads", pad_ctl_o, 3'b111);
            end
            EX_UP:   run_seq(3'b110, 3'b100, 3'b000, "R2 up");
            default: run_seq(3'b100, 3'b110, 3'b111, "R4 down");
        endcase
        @(negedge clk);
        chk("R6 pulse", ack_o, 0);
        chk("R8 pulse", warn_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pads", pad_ctl_o, 3'b111);
        chk("R1 busy", busy_o, 0);
        chk("R1 ack", ack_o, 0);
        chk("R1 warn", warn_o, 0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][3:2], VEC[i][1:0]);
        end

        // R9: pulses during a running power-up are ignored
        @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        chk("R9 start", pad_ctl_o, 3'b110);
        rel_i = 1'b1;
        @(negedge clk);
        rel_i = 1'b0;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (GAP - 3) @(negedge clk);
        chk("R9 pads held", pad_ctl_o, 3'b110);
        chk("R9 no ack", ack_o, 0);
        chk("R9 no warn", warn_o, 0);
        @(negedge clk);
        chk("R9 step", pad_ctl_o, 3'b100);
        repeat (GAP) @(negedge clk);
        chk("R9 done", pad_ctl_o, 3'b000);
        chk("R9 ack", ack_o, 1);
        cur_pads = 3'b000;
        // count must still be one: a single release powers down
        apply(OP_REL, EX_DN);

        // R1: reset mid-sequence restores asserted bits and zero count
        @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (GAP + 1) @(negedge clk);
        chk("R1 mid", pad_ctl_o, 3'b100);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pads", pad_ctl_o, 3'b111);
        chk("R1 busy", busy_o, 0);
        cur_pads = 3'b111;
        apply(OP_REQ, EX_UP);
        apply(OP_REL, EX_DN);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule